// File: doc/BRIEF.md
# Radio Transmit Trigger and Interrupt Unit

This block is the control and status logic between a host register port and the frame engines of a packet radio. The host launches a send by writing a trigger bit. The block gives the transmitter a one-cycle start pulse and keeps the trigger bit readable as busy until the transmitter reports completion. The completion report carries a pass/fail flag, which the block latches into a transmit status register.

Completed sends and accepted received frames each set a bit in an interrupt status register. Reading that register returns its contents and clears it. A separate register holds active-high disable bits, one per source. The interrupt output is active-low and is meant for a host that detects its falling edge. A receive-hold bit lets the host stop new frames from being accepted while it drains the receive buffer. A frame that arrives while the hold is set is dropped and leaves no status behind.

All registers are 8 bits wide. The host reaches them through a single-cycle write strobe and a read strobe. Read data is registered.

Top module: `txirq_unit`

## Requirements
- R1: Writing a 1 to bit 0 of the transmit-control register (address 0x1B) while idle raises `tx_start` for exactly the one cycle after the write. Bit 0 then reads 1 until `tx_done` is seen, and reads 0 afterwards.
- R2: Bit 2 of the transmit-control register is stored on every write to that register, drives `tx_ack_req`, and reads back at bit 2. A 0 there means a plain send without acknowledgement.
- R3: A trigger written while a send is pending produces no `tx_start`. A `tx_done` arriving while no send is pending sets no status bit.
- R4: The transmit status register (0x24) bit 0 holds the value of `tx_fail` sampled with the accepted `tx_done`. A 1 there means the retry count was exceeded.
- R5: An accepted `tx_done` sets bit 0 of the interrupt status register (0x31). An accepted frame sets bit 3 of that register. A read returns the register value on `reg_rdata` in the cycle after the read strobe.
- R6: `irq_n` is low in the cycle after an event sets a status bit whose disable bit is clear.
- R7: Reading the interrupt status register clears all its bits in the same access. `irq_n` is high in the following cycle unless a new event arrived.
- R8: The interrupt control register (0x32) resets to 0xFF and reads back in full. Setting bit 0 disables the transmit interrupt, and setting bit 3 disables the receive interrupt. A status bit that is set while disabled still latches, and it pulls `irq_n` low once its disable bit is cleared.
- R9: Bit 2 of the baseband register (0x39) is the receive hold and drives `rx_hold`. While it is 1, `rx_frame` is dropped: there is no `rx_accept` and no status bit is set. While it is 0, each `rx_frame` gives `rx_accept` in the next cycle.
- R10: An event that arrives in the same cycle as a clearing read of the interrupt status register survives the clear. The read returns the value from before the event.
- R11: Addresses other than the five listed read as 0. Bits other than those named in the transmit, status and baseband registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tx_done | input | 1 | Transmitter completion pulse |
| tx_fail | input | 1 | Retries exhausted, valid with tx_done |
| rx_frame | input | 1 | Receiver frame-arrived pulse |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| tx_ack_req | output | 1 | Acknowledge-request setting for the send |
| rx_accept | output | 1 | Frame accepted into the receive buffer |
| rx_hold | output | 1 | Receive decode held off |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each result has a fixed latency. `tx_start`, `rx_accept`, the status bits and `irq_n` all change at the first clock edge that samples their stimulus. `reg_rdata` and the clear-on-read also take effect at that edge. The bench drives inputs on the falling edge and checks ports on the next falling edge, which is half a cycle after the one edge where the result appears. Read results pass through a queue: each expected value is pushed when its read is issued, and a monitor pops it on the falling edge after the clock edge that sampled the strobe.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
   // Register selected by the address decoder.
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_TXCTL,
      SEL_TXSTAT,
      SEL_ISTAT,
      SEL_ICTL,
      SEL_BB
   } regsel_e;
endpackage

// File: rtl/txirq_tx_ctl.sv
module txirq_tx_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic trig_bit,
   input  logic ack_bit,
   input  logic done_i,
   input  logic fail_i,
   output logic start_o,
   output logic busy_o,
   output logic ack_o,
   output logic fail_o,
   output logic done_evt_o
);
   logic busy_q, start_q, ack_q, fail_q;

   // Only a completion for a pending send counts.
   assign done_evt_o = done_i & busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         ack_q   <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (ctl_wr)
            ack_q <= ack_bit;
         if (done_evt_o) begin
            busy_q <= 1'b0;
            fail_q <= fail_i;
         end else if (ctl_wr && trig_bit && !busy_q) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
         end
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;
   assign ack_o   = ack_q;
   assign fail_o  = fail_q;
endmodule

// File: rtl/txirq_rx_gate.sv
module txirq_rx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic bb_wr,
   input  logic hold_bit,
   input  logic frame_i,
   output logic hold_o,
   output logic evt_o,
   output logic accept_o
);
   logic hold_q, accept_q;

   assign evt_o = frame_i & ~hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= 1'b0;
         accept_q <= 1'b0;
      end else begin
         accept_q <= evt_o;
         if (bb_wr)
            hold_q <= hold_bit;
      end
   end

   assign hold_o   = hold_q;
   assign accept_o = accept_q;
endmodule

// File: rtl/txirq_irq_ctl.sv
module txirq_irq_ctl #(
   parameter int DATA_W  = 8,
   parameter int TX_BIT  = 0,
   parameter int RX_BIT  = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_evt,
   input  logic              rx_evt,
   input  logic              rd_clr,
   input  logic              dis_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stat_o,
   output logic [DATA_W-1:0] dis_o,
   output logic              irq_n
);
   localparam logic [DATA_W-1:0] SRC_MASK =
      (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT);

   logic [DATA_W-1:0] stat_q, dis_q, set_v;

   always_comb begin
      set_v         = '0;
      set_v[TX_BIT] = tx_evt;
      set_v[RX_BIT] = rx_evt;
   end

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_stat
         if (SRC_MASK[i]) begin : g_src
            // A new event has priority over the clearing read.
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  stat_q[i] <= 1'b0;
               else
                  stat_q[i] <= set_v[i] | (stat_q[i] & ~rd_clr);
            end
         end else begin : g_tie
            assign stat_q[i] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dis_q <= '1;
      else if (dis_wr)
         dis_q <= wdata;
   end

   logic pend;
   assign pend = |(stat_q & ~dis_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b1;
            else
               irq_q <= ~pend;
         end
         assign irq_n = irq_q;
      end else begin : g_irq_comb
         assign irq_n = ~pend;
      end
   endgenerate

   assign stat_o = stat_q;
   assign dis_o  = dis_q;
endmodule

// File: rtl/txirq_unit.sv
module txirq_unit #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int A_TXCTL  = 'h1B,
   parameter int A_TXSTAT = 'h24,
   parameter int A_ISTAT  = 'h31,
   parameter int A_ICTL   = 'h32,
   parameter int A_BB     = 'h39,
   parameter int TRIG_BIT = 0,
   parameter int ACK_BIT  = 2,
   parameter int FAIL_BIT = 0,
   parameter int TX_BIT   = 0,
   parameter int RX_BIT   = 3,
   parameter int HOLD_BIT = 2,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_done,
   input  logic              tx_fail,
   input  logic              rx_frame,
   output logic              tx_start,
   output logic              tx_ack_req,
   output logic              rx_accept,
   output logic              rx_hold,
   output logic              irq_n
);
   import txirq_pkg::*;

   generate
      if (TX_BIT == RX_BIT) begin : g_bad_src
         $error("txirq_unit: interrupt sources share a bit");
      end
      if (TRIG_BIT == ACK_BIT) begin : g_bad_ctl
         $error("txirq_unit: trigger and ack bits overlap");
      end
      if (TX_BIT >= DATA_W || RX_BIT >= DATA_W || HOLD_BIT >= DATA_W ||
          TRIG_BIT >= DATA_W || ACK_BIT >= DATA_W || FAIL_BIT >= DATA_W) begin : g_bad_w
         $error("txirq_unit: bit position beyond data width");
      end
      if (A_TXCTL >= (1 << ADDR_W) || A_BB >= (1 << ADDR_W) ||
          A_ISTAT >= (1 << ADDR_W) || A_ICTL >= (1 << ADDR_W) ||
          A_TXSTAT >= (1 << ADDR_W)) begin : g_bad_a
         $error("txirq_unit: address beyond address width");
      end
   endgenerate

   regsel_e sel;

   always_comb begin
      sel = SEL_NONE;
      if (reg_addr == ADDR_W'(A_TXCTL))       sel = SEL_TXCTL;
      else if (reg_addr == ADDR_W'(A_TXSTAT)) sel = SEL_TXSTAT;
      else if (reg_addr == ADDR_W'(A_ISTAT))  sel = SEL_ISTAT;
      else if (reg_addr == ADDR_W'(A_ICTL))   sel = SEL_ICTL;
      else if (reg_addr == ADDR_W'(A_BB))     sel = SEL_BB;
   end

   logic busy, ack, fail, tx_evt, rx_evt, hold;
   logic [DATA_W-1:0] stat, dis;

   txirq_tx_ctl u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (reg_wr && sel == SEL_TXCTL),
      .trig_bit   (reg_wdata[TRIG_BIT]),
      .ack_bit    (reg_wdata[ACK_BIT]),
      .done_i     (tx_done),
      .fail_i     (tx_fail),
      .start_o    (tx_start),
      .busy_o     (busy),
      .ack_o      (ack),
      .fail_o     (fail),
      .done_evt_o (tx_evt)
   );

   txirq_rx_gate u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bb_wr    (reg_wr && sel == SEL_BB),
      .hold_bit (reg_wdata[HOLD_BIT]),
      .frame_i  (rx_frame),
      .hold_o   (hold),
      .evt_o    (rx_evt),
      .accept_o (rx_accept)
   );

   txirq_irq_ctl #(
      .DATA_W  (DATA_W),
      .TX_BIT  (TX_BIT),
      .RX_BIT  (RX_BIT),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_evt (tx_evt),
      .rx_evt (rx_evt),
      .rd_clr (reg_rd && sel == SEL_ISTAT),
      .dis_wr (reg_wr && sel == SEL_ICTL),
      .wdata  (reg_wdata),
      .stat_o (stat),
      .dis_o  (dis),
      .irq_n  (irq_n)
   );

   logic [DATA_W-1:0] rmux;

   always_comb begin
      rmux = '0;
      case (sel)
         SEL_TXCTL: begin
            rmux[TRIG_BIT] = busy;
            rmux[ACK_BIT]  = ack;
         end
         SEL_TXSTAT: rmux[FAIL_BIT] = fail;
         SEL_ISTAT:  rmux = stat;
         SEL_ICTL:   rmux = dis;
         SEL_BB:     rmux[HOLD_BIT] = hold;
         default:    rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rmux;
   end

   assign tx_ack_req = ack;
   assign rx_hold    = hold;
endmodule

// File: rtl/txirq_unit_chk.sv
module txirq_unit_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int A_TXCTL  = 'h1B,
   parameter int A_ISTAT  = 'h31,
   parameter int TRIG_BIT = 0,
   parameter bit IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              tx_done,
   input logic              rx_frame,
   input logic              tx_start,
   input logic              rx_accept,
   input logic              rx_hold,
   input logic              irq_n
);
   // Send outstanding as seen from the ports.
   logic pend_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (tx_done)    pend_q <= 1'b0;
      else if (tx_start)   pend_q <= 1'b1;
   end

   p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_start) |-> $past(reg_wr && reg_addr == ADDR_W'(A_TXCTL) && reg_wdata[TRIG_BIT]));

   p_single_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !pend_q);

   p_drop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame && rx_hold) |=> !rx_accept);

   p_accept_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame && !rx_hold) |=> rx_accept);

   generate
      if (!IRQ_REG) begin : g_comb_chk
         p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(A_ISTAT) && !rx_frame && !tx_done) |=> irq_n);
      end
   endgenerate
endmodule

bind txirq_unit txirq_unit_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .A_TXCTL  (A_TXCTL),
   .A_ISTAT  (A_ISTAT),
   .TRIG_BIT (TRIG_BIT),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .tx_done   (tx_done),
   .rx_frame  (rx_frame),
   .tx_start  (tx_start),
   .rx_accept (rx_accept),
   .rx_hold   (rx_hold),
   .irq_n     (irq_n)
);

// File: tb/txirq_unit_bench.sv
`timescale 1ns/1ps
module txirq_unit_bench;
   localparam logic [5:0] A_TXCTL = 6'h1B, A_TXSTAT = 6'h24, A_ISTAT = 6'h31,
                          A_ICTL = 6'h32, A_BB = 6'h39;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic tx_done = 1'b0, tx_fail = 1'b0, rx_frame = 1'b0;
   logic tx_start, tx_ack_req, rx_accept, rx_hold, irq_n;

   always #10 clk = ~clk;

   txirq_unit u_txirq_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_done(tx_done), .tx_fail(tx_fail), .rx_frame(rx_frame),
      .tx_start(tx_start), .tx_ack_req(tx_ack_req), .rx_accept(rx_accept),
      .rx_hold(rx_hold), .irq_n(irq_n)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Read monitor: result due on the falling edge after the sampling edge.
   logic rd_pend = 1'b0;
   always @(posedge clk) rd_pend <= reg_rd;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            vectors++;
            miscompares++;
            $display("FAIL unexpected read: actual %h expected none", reg_rdata);
         end else begin
            chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag,
                     input logic with_rx);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a; rx_frame = with_rx;
      @(negedge clk);
      reg_rd = 1'b0; rx_frame = 1'b0;
   endtask

   task automatic done_pulse(input logic f);
      @(negedge clk);
      tx_done = 1'b1; tx_fail = f;
      @(negedge clk);
      tx_done = 1'b0; tx_fail = 1'b0;
   endtask

   task automatic rx_pulse();
      @(negedge clk);
      rx_frame = 1'b1;
      @(negedge clk);
      rx_frame = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // Reset state
      chk("R6 reset irq_n", {7'b0, irq_n}, 8'h01);
      chk("R1 reset tx_start", {7'b0, tx_start}, 8'h00);
      chk("R9 reset rx_hold", {7'b0, rx_hold}, 8'h00);
      rd(A_ICTL, 8'hFF, "R8 disable reset", 1'b0);
      rd(A_ISTAT, 8'h00, "R5 status reset", 1'b0);
      rd(6'h10, 8'h00, "R11 unlisted address", 1'b0);

      // Trigger a plain send
      wr(A_TXCTL, 8'h01);
      chk("R1 start pulse", {7'b0, tx_start}, 8'h01);
      chk("R2 plain send", {7'b0, tx_ack_req}, 8'h00);
      step();
      chk("R1 start one cycle", {7'b0, tx_start}, 8'h00);
      rd(A_TXCTL, 8'h01, "R1 busy readback", 1'b0);
      wr(A_TXCTL, 8'h01);
      chk("R3 retrigger ignored", {7'b0, tx_start}, 8'h00);

      // Completion with failure, interrupt enabled
      wr(A_ICTL, 8'h00);
      done_pulse(1'b1);
      chk("R6 irq on tx done", {7'b0, irq_n}, 8'h00);
      rd(A_TXCTL, 8'h00, "R1 trigger cleared", 1'b0);
      rd(A_TXSTAT, 8'h01, "R4 fail latched", 1'b0);
      rd(A_ISTAT, 8'h01, "R5 tx status bit", 1'b0);
      chk("R7 irq released", {7'b0, irq_n}, 8'h01);
      rd(A_ISTAT, 8'h00, "R7 read cleared", 1'b0);

      // Completion while idle is ignored
      done_pulse(1'b0);
      chk("R3 idle done no irq", {7'b0, irq_n}, 8'h01);
      rd(A_ISTAT, 8'h00, "R3 idle done no status", 1'b0);

      // Acknowledged send, successful
      wr(A_TXCTL, 8'h05);
      chk("R2 ack start", {7'b0, tx_start}, 8'h01);
      chk("R2 ack request", {7'b0, tx_ack_req}, 8'h01);
      rd(A_TXCTL, 8'h05, "R2 readback", 1'b0);
      done_pulse(1'b0);
      rd(A_TXSTAT, 8'h00, "R4 pass latched", 1'b0);
      rd(A_ISTAT, 8'h01, "R5 tx status again", 1'b0);

      // Receive accepted
      rx_pulse();
      chk("R9 accept", {7'b0, rx_accept}, 8'h01);
      chk("R6 irq on rx", {7'b0, irq_n}, 8'h00);
      rd(A_ISTAT, 8'h08, "R5 rx status bit", 1'b0);
      chk("R7 irq released rx", {7'b0, irq_n}, 8'h01);

      // Receive held off
      wr(A_BB, 8'h04);
      chk("R9 hold output", {7'b0, rx_hold}, 8'h01);
      rd(A_BB, 8'h04, "R9 hold readback", 1'b0);
      rx_pulse();
      chk("R9 held drop", {7'b0, rx_accept}, 8'h00);
      chk("R9 held no irq", {7'b0, irq_n}, 8'h01);
      rd(A_ISTAT, 8'h00, "R9 held no status", 1'b0);
      wr(A_BB, 8'h00);
      chk("R9 hold released", {7'b0, rx_hold}, 8'h00);

      // Receive interrupt disabled
      wr(A_ICTL, 8'h08);
      rx_pulse();
      chk("R8 masked no irq", {7'b0, irq_n}, 8'h01);
      rd(A_ICTL, 8'h08, "R8 disable readback", 1'b0);
      wr(A_ICTL, 8'h00);
      chk("R8 unmask raises irq", {7'b0, irq_n}, 8'h00);
      rd(A_ISTAT, 8'h08, "R8 status kept while masked", 1'b0);

      // Event coincident with clearing read
      wr(A_TXCTL, 8'h01);
      done_pulse(1'b0);
      rd(A_ISTAT, 8'h01, "R10 read returns old value", 1'b1);
      chk("R10 irq kept by new event", {7'b0, irq_n}, 8'h00);
      rd(A_ISTAT, 8'h08, "R10 new event survived", 1'b0);
      rd(A_TXSTAT, 8'h00, "R11 unused bits zero", 1'b0);

      repeat (3) step();
      if (exp_q.size() != 0) begin
         vectors++;
         miscompares++;
         $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
      end
      summary();
   end
endmodule